// File: doc/BRIEF.md
# Dual-Stream Path Swap Switch Controller

This block steers data between two parallel transform pipelines so that two independent sample streams can share the same pair of half-length sub-transform units. It contains two four-lane path switches and the sequencer that sets their modes. A switch in straight mode passes each lane to the output of the same index. A switch in crossed mode exchanges the upper and lower lane pairs, which moves data from one pipeline to the other. Straight mode serves hops that stay within one pipeline. Crossed mode serves hops that go between the two pipelines.

The sequencer treats a period of N clocks as two halves of N/2 clocks, where N is twice the parameter `HALF_LEN`. During the first half the first switch (A) crosses and the second switch (B) runs straight. During the second half the roles reverse, so the two switches are never in the same mode. A start pulse marks clock 1 of a period. Clocks with valid low are not counted, which pauses the schedule. Both switch outputs are registered, and each mode flag is delayed to line up with the data it routed. The transform arithmetic is outside this block.

Top module: `dual_path_switch`

## Requirements
- R1: In straight mode a switch routes input lane k to output lane k for all four lanes. Lane 0 occupies bits [DATA_W-1:0], and lane k occupies bits [(k+1)*DATA_W-1:k*DATA_W].
- R2: In crossed mode a switch routes input lanes 0,1,2,3 to output lanes 2,3,0,1.
- R3: Output lanes and mode flags are registered. The output seen after a clock edge is the input at that edge, routed by the mode in force at that edge. A flag value of 1 means crossed.
- R4: Counting from the start cycle as clock 1, A is crossed on valid clocks 1..HALF_LEN and straight on clocks HALF_LEN+1..2*HALF_LEN. The pattern then repeats with no further start.
- R5: B is always in the opposite mode to A, including in the flags.
- R6: A start pulse makes its own cycle clock 1 of a new period (A crossed), whatever the current position in the schedule. If valid is low in that cycle, the next valid clock is clock 1.
- R7: A cycle with valid low does not advance the schedule. The mode in the following cycle equals the mode in the low-valid cycle.
- R8: After reset all output lanes are zero, the A flag is 1 and the B flag is 0. Until the first start, A stays crossed and B stays straight, whatever valid does.
- R9: Data is registered and routed on every clock, including clocks with valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Marks clock 1 of a period |
| valid | input | 1 | Clock counts toward the schedule when high |
| aIn | input | 4*DATA_W | Four input lanes of switch A |
| bIn | input | 4*DATA_W | Four input lanes of switch B |
| aOut | output | 4*DATA_W | Registered routed lanes of switch A |
| bOut | output | 4*DATA_W | Registered routed lanes of switch B |
| aSwap | output | 1 | Mode of A for the data on aOut (1 = crossed) |
| bSwap | output | 1 | Mode of B for the data on bOut (1 = crossed) |

## Verification
The bench builds the block with HALF_LEN = 4 and DATA_W = 16. With these values a full period is only eight clocks, so three complete wraps, a run with valid gaps, a restart in the middle of a half and a start with valid low all fit into a short run. Each input lane carries a tag made of its switch, its lane number and the cycle count. Any wrong lane, wrong switch or wrong cycle therefore shows up directly in the compared value.

// File: rtl/pathsw_pkg.sv
package pathsw_pkg;
  localparam int LANES = 4;

  // Mode strobes from the sequencer to the datapath (1 = crossed)
  typedef struct packed {
    logic swapA;
    logic swapB;
  } swCtrl_t;
endpackage

// File: rtl/pathsw_seq.sv
module pathsw_seq
  import pathsw_pkg::*;
#(
  parameter int HALF_LEN = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    valid,
  output swCtrl_t ctrl
);
  localparam int CNT_W = (HALF_LEN > 1) ? $clog2(HALF_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_LEN - 1);

  logic [CNT_W-1:0] cntQ, cntCur;
  logic phaseQ, phaseCur, runQ, lastBeat, advance;

  always_comb begin
    cntCur   = start ? '0 : cntQ;
    phaseCur = start ? 1'b0 : phaseQ;
    lastBeat = (cntCur == LAST);
    advance  = valid & (runQ | start);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      phaseQ <= 1'b0;
      runQ   <= 1'b0;
    end else begin
      if (start) runQ <= 1'b1;
      if (advance) begin
        cntQ   <= lastBeat ? '0 : cntCur + 1'b1;
        phaseQ <= phaseCur ^ lastBeat;
      end else if (start) begin
        cntQ   <= '0;
        phaseQ <= 1'b0;
      end
    end
  end

  // phase 0: A crossed, B straight; phase 1: reversed
  always_comb begin
    ctrl.swapA = ~phaseCur;
    ctrl.swapB = phaseCur;
  end
endmodule

// File: rtl/pathsw_datapath.sv
module pathsw_datapath
  import pathsw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  swCtrl_t                 ctrl,
  input  logic [LANES*DATA_W-1:0] aIn,
  input  logic [LANES*DATA_W-1:0] bIn,
  output logic [LANES*DATA_W-1:0] aOut,
  output logic [LANES*DATA_W-1:0] bOut,
  output logic                    aSwap,
  output logic                    bSwap
);
  localparam int BUS_W  = LANES * DATA_W;
  localparam int PAIR_W = BUS_W / 2;

  logic [BUS_W-1:0] inBus  [2];
  logic [BUS_W-1:0] outBus [2];
  logic             selBus [2];
  logic             flagBus[2];

  assign inBus[0]  = aIn;
  assign inBus[1]  = bIn;
  assign selBus[0] = ctrl.swapA;
  assign selBus[1] = ctrl.swapB;

  for (genvar g = 0; g < 2; g++) begin : g_sw
    localparam logic FLAG_RST = (g == 0);
    logic [BUS_W-1:0] routed, dataQ;
    logic             flagQ;

    // crossed: lower lane pair and upper lane pair exchange places
    assign routed = selBus[g] ? {inBus[g][PAIR_W-1:0], inBus[g][BUS_W-1:PAIR_W]}
                              : inBus[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= '0;
        flagQ <= FLAG_RST;
      end else begin
        dataQ <= routed;
        flagQ <= selBus[g];
      end
    end

    assign outBus[g]  = dataQ;
    assign flagBus[g] = flagQ;
  end

  assign aOut  = outBus[0];
  assign bOut  = outBus[1];
  assign aSwap = flagBus[0];
  assign bSwap = flagBus[1];
endmodule

// File: rtl/dual_path_switch.sv
module dual_path_switch
  import pathsw_pkg::*;
#(
  parameter int HALF_LEN = 8,
  parameter int DATA_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    valid,
  input  logic [LANES*DATA_W-1:0] aIn,
  input  logic [LANES*DATA_W-1:0] bIn,
  output logic [LANES*DATA_W-1:0] aOut,
  output logic [LANES*DATA_W-1:0] bOut,
  output logic                    aSwap,
  output logic                    bSwap
);
  swCtrl_t ctrl;

  pathsw_seq #(.HALF_LEN(HALF_LEN)) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .valid(valid), .ctrl(ctrl)
  );

  pathsw_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut),
    .aSwap(aSwap), .bSwap(bSwap)
  );
endmodule

// File: rtl/dual_path_switch_chk.sv
module dual_path_switch_chk #(
  parameter int HALF_LEN = 8,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                valid,
  input logic [4*DATA_W-1:0] aIn,
  input logic [4*DATA_W-1:0] bIn,
  input logic [4*DATA_W-1:0] aOut,
  input logic [4*DATA_W-1:0] bOut,
  input logic                aSwap,
  input logic                bSwap
);
  localparam int HW = 2 * DATA_W;
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  p_straight_route_r1: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (!aSwap |-> aOut == $past(aIn)) and (!bSwap |-> bOut == $past(bIn)));

  p_cross_route_r2: assert property (@(posedge clk) disable iff (!rstN || !primed)
    (aSwap |-> aOut == {$past(aIn[HW-1:0]), $past(aIn[4*DATA_W-1:HW])}) and
    (bSwap |-> bOut == {$past(bIn[HW-1:0]), $past(bIn[4*DATA_W-1:HW])}));

  p_opposite_r5: assert property (@(posedge clk) disable iff (!rstN)
    aSwap != bSwap);

  p_start_cross_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (aSwap && !bSwap));

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && !start) ##1 !start |=> $stable(aSwap));
endmodule

bind dual_path_switch dual_path_switch_chk #(.HALF_LEN(HALF_LEN), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .valid(valid), .aIn(aIn), .bIn(bIn),
  .aOut(aOut), .bOut(bOut), .aSwap(aSwap), .bSwap(bSwap)
);

// File: tb/dual_path_switch_test.sv
module dual_path_switch_test;
  localparam int HALF = 4;
  localparam int DW   = 16;
  localparam int N    = 2 * HALF;
  localparam int BW   = 4 * DW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, start, valid, aSwap, bSwap;
  logic [BW-1:0] aIn, bIn, aOut, bOut;

  dual_path_switch #(.HALF_LEN(HALF), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .valid(valid), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut), .aSwap(aSwap), .bSwap(bSwap)
  );

  typedef struct {
    logic [BW-1:0] a, b;
    logic fa, fb;
    string tagD, tagF;
  } exp_t;
  exp_t q[$];

  int vectors = 0, miscompares = 0, cyc = 0;
  int mCnt = 0;
  bit mPhase = 0, mRun = 0, mPrevVl = 1;

  function automatic logic [BW-1:0] crossed(input logic [BW-1:0] x);
    return {x[2*DW-1:0], x[BW-1:2*DW]};
  endfunction

  function automatic logic [DW-1:0] laneTag(input int sw, input int lane, input int c);
    return {sw[0], lane[1:0], c[12:0]};
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input bit st, input bit vl);
    exp_t e;
    int curCnt;
    bit curPh, aCross;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      aIn[k*DW +: DW] = laneTag(0, k, cyc);
      bIn[k*DW +: DW] = laneTag(1, k, cyc);
    end
    start = st;
    valid = vl;
    curCnt = st ? 0 : mCnt;
    curPh  = st ? 1'b0 : mPhase;
    aCross = (curPh == 1'b0);          // R4: first half of a period has A crossed
    e.a  = aCross ? crossed(aIn) : aIn;
    e.b  = aCross ? bIn : crossed(bIn); // R5: B opposite
    e.fa = aCross;
    e.fb = !aCross;
    e.tagD = {aCross ? "R2" : "R1", vl ? " R3" : " R9"};
    if (st)                e.tagF = "R6";
    else if (!mRun)        e.tagF = "R8";
    else if (!mPrevVl)     e.tagF = "R7";
    else                   e.tagF = "R4";
    q.push_back(e);
    if (st) mRun = 1;
    if (vl && mRun) begin
      if (curCnt == HALF - 1) begin mCnt = 0; mPhase = !curPh; end
      else begin mCnt = curCnt + 1; mPhase = curPh; end
    end else if (st) begin
      mCnt = 0; mPhase = 0;
    end
    mPrevVl = vl;
    cyc++;
  endtask

  // monitor: compares registered outputs after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        check({"A data ", e.tagD}, aOut, e.a);
        check({"B data ", e.tagD}, bOut, e.b);
        check({"A flag ", e.tagF}, BW'(aSwap), BW'(e.fa));
        check({"B flag R5 ", e.tagF}, BW'(bSwap), BW'(e.fb));
      end
    end
  end

  initial begin
    #(8 * 20000);
    miscompares++;
    $display("FAIL watchdog R3 actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; valid = 1'b0; aIn = '0; bIn = '0;
    repeat (3) @(negedge clk);
    check("reset A data R8", aOut, '0);
    check("reset B data R8", bOut, '0);
    check("reset A flag R8", BW'(aSwap), BW'(1));
    check("reset B flag R8", BW'(bSwap), BW'(0));
    rstN = 1'b1;
    // idle before any start, with valid toggling (R8)
    drive(0, 1); drive(0, 0); drive(0, 1);
    // three full periods without restart (R4 wrap)
    drive(1, 1);
    repeat (3 * N - 1) drive(0, 1);
    // valid gaps pause the schedule (R7, R9)
    for (int i = 0; i < 24; i++) drive(0, (i % 3) != 0);
    // restart in the middle of a half (R6)
    repeat (2) drive(0, 1);
    drive(1, 1);
    repeat (5) drive(0, 1);
    // start with valid low: next valid clock is clock 1 (R6)
    drive(1, 0);
    repeat (HALF + 3) drive(0, 1);
    start = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule